// File: doc/BRIEF.md
# Pre-Trigger Circular Bus Waveform Capture

This block records a wide snapshot of bus activity on every clock into a circular sample store of `DEPTH` entries. Each snapshot holds the bus address, bus data and a word of miscellaneous bus lines, each in its own memory. A fourth, narrower memory is written in the same cycle and holds the address-modifier code, the seven interrupt-request lines and a flag that marks the trigger sample. Once armed, the store is written continuously and wraps around. When the selected trigger condition is met, the block takes a programmed number of further samples and then stops. The trigger therefore sits at a programmable position inside the frozen record.

The trigger compares one of several bus fields against a match value under a mask. Only the bits whose mask bit is 1 take part in the comparison. The block can trigger on an address match (the modifier code is not looked at), on a modifier-code match, on a modifier code that does *not* match (a "not valid code" watch), or on any interrupt request level.

A small register port sets up the trigger. A write to the control register arms a new capture. A sequential read port then returns the frozen record, starting with the oldest sample.

Top module: `wave_capture`

## Requirements
- R1: After a synchronous active-low reset, `acquiring` and `data_ready` are both 0.
- R2: A write with `cfg_addr`=3 arms a capture. Its fields are: source in bits [1:0], pre-trigger position in bits [16+AW-1:16]. `acquiring` is 1 on the cycle after the write, and the record restarts empty.
- R3: Source 0 (address) fires when `((smp_addr ^ match) & mask) == 0`. The mask is written at `cfg_addr`=0 and the match at `cfg_addr`=1. Address bits with mask 0 never affect the result.
- R4: Both modifier sources use the mask in bits [AM_W-1:0] and the match in bits [8+AM_W-1:8] of `cfg_addr`=2. Source 1 fires when the masked modifier code equals the match. Source 2 fires when it differs.
- R5: Source 3 fires when any of the `smp_irq` lines (levels 1..7 on bits 0..6) is 1.
- R6: `acquiring` falls at the clock edge that samples the trigger. Exactly `DEPTH-1-pre` further samples are then stored, and after that `data_ready` rises. `acquiring` and `data_ready` are never 1 together.
- R7: In the frozen record, the sample that met the trigger sits at record index `pre` (index 0 is the oldest) and has `rd_trig`=1. No other valid entry has `rd_trig`=1.
- R8: `rd_rewind` moves the read index to record index 0. Each `rd_step` cycle advances it by one, wrapping modulo `DEPTH`. Output data for an index appears one clock after that index is current.
- R9: A trigger that arrives after only k < pre samples is still accepted. Record indices below `pre-k` then read with `rd_valid`=0, and all other indices read with `rd_valid`=1.
- R10: Once `data_ready` is 1, trigger conditions are ignored. `data_ready` stays 1 and the record is unchanged until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_addr | input | BUS_W | Bus address lines |
| smp_data | input | BUS_W | Bus data lines |
| smp_lines | input | BUS_W | Miscellaneous bus lines |
| smp_am | input | AM_W | Address-modifier code |
| smp_irq | input | IRQ_N | Interrupt request lines, bit 0 = level 1 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 address mask, 1 address match, 2 modifier mask/match, 3 control/arm |
| cfg_wdata | input | BUS_W | Register write data |
| rd_rewind | input | 1 | Move the read index to the oldest sample |
| rd_step | input | 1 | Advance the read index by one |
| rd_addr | output | BUS_W | Stored address |
| rd_data | output | BUS_W | Stored data |
| rd_lines | output | BUS_W | Stored miscellaneous lines |
| rd_am | output | AM_W | Stored modifier code |
| rd_irq | output | IRQ_N | Stored interrupt lines |
| rd_trig | output | 1 | Entry is the trigger sample |
| rd_valid | output | 1 | Entry was written during this capture |
| acquiring | output | 1 | Armed and waiting for the trigger |
| data_ready | output | 1 | Record frozen and ready for read-out |

## Verification
The bound checker watches the status handshake on every cycle. An arm always leads to `acquiring`. `acquiring` only falls on a cycle where the comparator fired. The two status flags are never both set. `data_ready` holds until the next arm. The bench scenarios cover what only the stored record can show: the masked compare for each source, the exact post-trigger sample count, the trigger's index, read-out order with wraparound, and the invalid prefix left by an early trigger.

// File: rtl/wcap_pkg.sv
// Shared types for the circular waveform capture block.
// Assumes: register select is 2 bits wide; the state encoding is internal.
package wcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } wcap_state_e;

    typedef enum logic [1:0] {
        SRC_ADDR   = 2'd0,
        SRC_AM     = 2'd1,
        SRC_AM_NOT = 2'd2,
        SRC_IRQ    = 2'd3
    } wcap_src_e;

    localparam logic [1:0] CFG_ADDR_MASK  = 2'd0;
    localparam logic [1:0] CFG_ADDR_MATCH = 2'd1;
    localparam logic [1:0] CFG_AM         = 2'd2;
    localparam logic [1:0] CFG_CTRL       = 2'd3;
endpackage

// File: rtl/wcap_trigger.sv
// Trigger comparator: a masked compare on one selected bus field.
// Purely combinational. A mask bit of 1 makes that bit take part in the compare.
// Assumes the source code is one of the four wcap_src_e values.
module wcap_trigger
    import wcap_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int AM_W  = 6,
    parameter int IRQ_N = 7
) (
    input  logic [1:0]       src,
    input  logic [BUS_W-1:0] addr,
    input  logic [AM_W-1:0]  am,
    input  logic [IRQ_N-1:0] irq,
    input  logic [BUS_W-1:0] addr_mask,
    input  logic [BUS_W-1:0] addr_match,
    input  logic [AM_W-1:0]  am_mask,
    input  logic [AM_W-1:0]  am_match,
    output logic             hit
);
    logic addr_eq;
    logic am_eq;

    // Select the compare result for the chosen source.
    always_comb begin
        addr_eq = ((addr ^ addr_match) & addr_mask) == '0;
        am_eq   = ((am ^ am_match) & am_mask) == '0;
        unique case (wcap_src_e'(src))
            SRC_ADDR:   hit = addr_eq;
            SRC_AM:     hit = am_eq;
            SRC_AM_NOT: hit = !am_eq;
            default:    hit = |irq;
        endcase
    end
endmodule

// File: rtl/wcap_ctrl.sv
// Capture control FSM and write-pointer logic.
// IDLE -> PRE on arm. PRE writes continuously until the trigger.
// POST writes DEPTH-1-pre further samples. DONE holds the record.
// Assumes DEPTH is a power of two, so the pointer wraps naturally.
module wcap_ctrl
    import wcap_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          hit,
    input  logic [AW-1:0] pre,
    output wcap_state_e   state,
    output logic          wr_en,
    output logic          trig_mark,
    output logic [AW-1:0] wr_ptr,
    output logic [AW:0]   filled
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL = (AW + 1)'(DEPTH);

    logic [AW-1:0] post_left;

    // Write strobe and trigger marker for the current sample.
    always_comb begin
        wr_en     = (state == ST_PRE || state == ST_POST) && !arm;
        trig_mark = (state == ST_PRE) && hit && !arm;
    end

    // State, pointer, fill level and post-trigger countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wr_ptr    <= '0;
            filled    <= '0;
            post_left <= '0;
        end else if (arm) begin
            state  <= ST_PRE;
            wr_ptr <= '0;
            filled <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (filled != FULL) filled <= filled + 1'b1;
            if (state == ST_PRE) begin
                if (hit) begin
                    post_left <= LAST - pre;
                    state     <= (pre == LAST) ? ST_DONE : ST_POST;
                end
            end else begin
                post_left <= post_left - 1'b1;
                if (post_left == AW'(1)) state <= ST_DONE;
            end
        end
    end
endmodule

// File: rtl/wcap_store.sv
// Sample store: NLANE parallel lane memories plus a control-word memory,
// all sharing one write address and one registered read address.
// Assumes a single write port and a single read port.
module wcap_store #(
    parameter int DEPTH  = 2048,
    parameter int NLANE  = 3,
    parameter int LANE_W = 32,
    parameter int CW     = 14,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [AW-1:0]                 waddr,
    input  logic [NLANE-1:0][LANE_W-1:0]  wlanes,
    input  logic [CW-1:0]                 wctrl,
    input  logic [AW-1:0]                 raddr,
    output logic [NLANE-1:0][LANE_W-1:0]  rlanes,
    output logic [CW-1:0]                 rctrl
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        // Write and read one lane memory.
        always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wlanes[g];
            rlanes[g] <= mem[raddr];
        end
    end

    logic [CW-1:0] cmem [DEPTH];
    // Write and read the control-word memory alongside the lanes.
    always_ff @(posedge clk) begin
        if (we) cmem[waddr] <= wctrl;
        rctrl <= cmem[raddr];
    end
endmodule

// File: rtl/wave_capture.sv
// Top level of the circular waveform capture.
// Holds the configuration registers, the read index and the status outputs.
// Assumes BUS_W >= 16 + AW, BUS_W >= 8 + AM_W, and DEPTH a power of two.
module wave_capture
    import wcap_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int BUS_W = 32,
    parameter int AM_W  = 6,
    parameter int IRQ_N = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] smp_addr,
    input  logic [BUS_W-1:0] smp_data,
    input  logic [BUS_W-1:0] smp_lines,
    input  logic [AM_W-1:0]  smp_am,
    input  logic [IRQ_N-1:0] smp_irq,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [BUS_W-1:0] cfg_wdata,
    input  logic             rd_rewind,
    input  logic             rd_step,
    output logic [BUS_W-1:0] rd_addr,
    output logic [BUS_W-1:0] rd_data,
    output logic [BUS_W-1:0] rd_lines,
    output logic [AM_W-1:0]  rd_am,
    output logic [IRQ_N-1:0] rd_irq,
    output logic             rd_trig,
    output logic             rd_valid,
    output logic             acquiring,
    output logic             data_ready
);
    localparam int AW    = $clog2(DEPTH);
    localparam int NLANE = 3;
    localparam int CW    = AM_W + IRQ_N + 1;

    logic [BUS_W-1:0] addr_mask, addr_match;
    logic [AM_W-1:0]  am_mask, am_match;
    logic [1:0]       trg_src;
    logic [AW-1:0]    pre_pos;
    logic             arm, trig_hit, wr_en, trig_mark;
    wcap_state_e      state;
    logic [AW-1:0]    wr_ptr, ridx;
    logic [AW:0]      filled;
    logic [NLANE-1:0][BUS_W-1:0] lanes_in, lanes_out;
    logic [CW-1:0]    ctrl_out;
    logic             cfg_unused;

    assign arm        = cfg_we && (cfg_addr == CFG_CTRL);
    assign cfg_unused = ^{cfg_wdata[BUS_W-1:16+AW], cfg_wdata[15:8+AM_W],
                          cfg_wdata[7:AM_W]};

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_mask  <= '0;
            addr_match <= '0;
            am_mask    <= '0;
            am_match   <= '0;
            trg_src    <= '0;
            pre_pos    <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                CFG_ADDR_MASK:  addr_mask  <= cfg_wdata;
                CFG_ADDR_MATCH: addr_match <= cfg_wdata;
                CFG_AM: begin
                    am_mask  <= cfg_wdata[AM_W-1:0];
                    am_match <= cfg_wdata[8+AM_W-1:8];
                end
                default: begin
                    trg_src <= cfg_wdata[1:0];
                    pre_pos <= cfg_wdata[16+AW-1:16];
                end
            endcase
        end
    end

    wcap_trigger #(.BUS_W(BUS_W), .AM_W(AM_W), .IRQ_N(IRQ_N)) u_trig (
        .src(trg_src), .addr(smp_addr), .am(smp_am), .irq(smp_irq),
        .addr_mask(addr_mask), .addr_match(addr_match),
        .am_mask(am_mask), .am_match(am_match), .hit(trig_hit)
    );

    wcap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .hit(trig_hit), .pre(pre_pos),
        .state(state), .wr_en(wr_en), .trig_mark(trig_mark),
        .wr_ptr(wr_ptr), .filled(filled)
    );

    assign lanes_in[0] = smp_addr;
    assign lanes_in[1] = smp_data;
    assign lanes_in[2] = smp_lines;

    wcap_store #(.DEPTH(DEPTH), .NLANE(NLANE), .LANE_W(BUS_W), .CW(CW)) u_store (
        .clk(clk), .we(wr_en), .waddr(wr_ptr), .wlanes(lanes_in),
        .wctrl({trig_mark, smp_irq, smp_am}),
        .raddr(wr_ptr + ridx), .rlanes(lanes_out), .rctrl(ctrl_out)
    );

    // Read index (relative to the oldest sample) and registered valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ridx     <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (rd_rewind)    ridx <= '0;
            else if (rd_step) ridx <= ridx + 1'b1;
            rd_valid <= {1'b0, ridx} >= ((AW + 1)'(DEPTH) - filled);
        end
    end

    assign rd_addr    = lanes_out[0];
    assign rd_data    = lanes_out[1];
    assign rd_lines   = lanes_out[2];
    assign rd_am      = ctrl_out[AM_W-1:0];
    assign rd_irq     = ctrl_out[AM_W+IRQ_N-1:AM_W];
    assign rd_trig    = ctrl_out[CW-1];
    assign acquiring  = (state == ST_PRE);
    assign data_ready = (state == ST_DONE);
endmodule

// File: rtl/wcap_checker.sv
// Protocol checker for wave_capture status behaviour; attached by bind.
// Assumes the bound signals are the top's arm strobe and comparator output.
module wcap_checker (
    input logic clk,
    input logic rst_n,
    input logic arm,
    input logic hit,
    input logic acquiring,
    input logic data_ready
);
    assert_arm_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> acquiring);

    assert_drop_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acquiring) |-> $past(hit));

    assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acquiring && data_ready));

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !arm) |=> data_ready);
endmodule

bind wave_capture wcap_checker chk_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(trig_hit),
    .acquiring(acquiring), .data_ready(data_ready)
);

// File: tb/wave_capture_tb_top.sv
// Directed bench for wave_capture: one task per scenario, each self-checking.
module wave_capture_tb_top;
    localparam int DEPTH = 2048;
    localparam int AW    = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] smp_addr = '0, stamp = '0, cfg_wdata = '0;
    logic [5:0]  smp_am = '0;
    logic [6:0]  smp_irq = '0;
    logic        cfg_we = 1'b0, rd_rewind = 1'b0, rd_step = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] rd_addr, rd_data, rd_lines;
    logic [5:0]  rd_am;
    logic [6:0]  rd_irq;
    logic        rd_trig, rd_valid, acquiring, data_ready;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;
    logic [31:0] rdd [DEPTH];
    logic        rdt [DEPTH];
    logic        rdv [DEPTH];
    logic [31:0] wrap_d;

    always #10 clk = ~clk;
    always @(posedge clk) stamp <= stamp + 1;

    wave_capture dut_i (
        .clk(clk), .rst_n(rst_n), .smp_addr(smp_addr), .smp_data(stamp),
        .smp_lines(~stamp), .smp_am(smp_am), .smp_irq(smp_irq),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_rewind(rd_rewind), .rd_step(rd_step), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_lines(rd_lines), .rd_am(rd_am), .rd_irq(rd_irq),
        .rd_trig(rd_trig), .rd_valid(rd_valid), .acquiring(acquiring),
        .data_ready(data_ready)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    // Arm, run k idle samples, fire once, wait out the post phase (R2, R6).
    task automatic capture(input int pre, input int k, input logic [1:0] src,
                           input logic [31:0] h_addr, input logic [5:0] h_am,
                           input logic [6:0] h_irq, output logic [31:0] ts);
        logic [31:0] i_addr = smp_addr;
        logic [5:0]  i_am = smp_am;
        logic [6:0]  i_irq = smp_irq;
        int post = DEPTH - 1 - pre;
        cfg_write(2'd3, (32'(pre) << 16) | 32'(src));
        check(acquiring === 1'b1, "R2 acquiring after arm", 32'(acquiring), 1);
        repeat (k) tick();
        check(acquiring === 1'b1, "R3/R4 no false trigger", 32'(acquiring), 1);
        smp_addr = h_addr; smp_am = h_am; smp_irq = h_irq; ts = stamp;
        tick();
        smp_addr = i_addr; smp_am = i_am; smp_irq = i_irq;
        check(acquiring === 1'b0, "R6 acquiring drops at trigger", 32'(acquiring), 0);
        if (post > 0) begin
            repeat (post - 1) tick();
            check(data_ready === 1'b0, "R6 ready not early", 32'(data_ready), 0);
            tick();
        end
        check(data_ready === 1'b1, "R6 ready after post count", 32'(data_ready), 1);
    endtask

    // Stream the whole record, then one more step to see the wrap (R8).
    task automatic read_all();
        rd_rewind = 1'b1;
        tick();
        rd_rewind = 1'b0; rd_step = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            tick();
            rdd[i] = rd_data; rdt[i] = rd_trig; rdv[i] = rd_valid;
        end
        tick();
        wrap_d = rd_data;
        rd_step = 1'b0;
    endtask

    // Compare the record against the stamps (R7, R8, R9).
    task automatic verify(input int pre, input int k, input logic [31:0] ts);
        int first = (k >= pre) ? 0 : pre - k;
        int bad_v = 0, bad_d = 0, bad_t = 0;
        read_all();
        for (int i = 0; i < DEPTH; i++) begin
            if (rdv[i] !== (i >= first)) bad_v++;
            if (i >= first) begin
                if (rdd[i] !== ts - 32'(pre) + 32'(i)) bad_d++;
                if (rdt[i] !== (i == pre)) bad_t++;
            end
        end
        check(bad_v == 0, "R9 valid marking", 32'(bad_v), 0);
        check(bad_d == 0, "R8 oldest-first order", 32'(bad_d), 0);
        check(bad_t == 0, "R7 trigger flag placement", 32'(bad_t), 0);
        check(rdd[pre] === ts, "R7 trigger sample at pre", rdd[pre], ts);
        check(wrap_d === rdd[0], "R8 read wraps to oldest", wrap_d, rdd[0]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(acquiring === 1'b0, "R1 acquiring after reset", 32'(acquiring), 0);
        check(data_ready === 1'b0, "R1 ready after reset", 32'(data_ready), 0);
    endtask

    task automatic t_addr();
        logic [31:0] ts;
        cfg_write(2'd0, 32'hFFFF_0000);
        cfg_write(2'd1, 32'h1234_0000);
        smp_addr = 32'h1235_0000;  // differs in a compared bit
        capture(100, 300, 2'd0, 32'h1234_ABCD, 6'h0, 7'h0, ts);  // R3
        verify(100, 300, ts);
    endtask

    task automatic t_am();
        logic [31:0] ts;
        cfg_write(2'd2, 32'h0000_093F);
        smp_am = 6'h0D;
        capture(DEPTH - 1, 2100, 2'd1, smp_addr, 6'h09, 7'h0, ts);  // R4 match
        verify(DEPTH - 1, 2100, ts);
    endtask

    task automatic t_am_not();
        logic [31:0] ts;
        cfg_write(2'd2, 32'h0000_0938);
        smp_am = 6'h0E;  // differs only in masked-off bits
        capture(0, 50, 2'd2, smp_addr, 6'h31, 7'h0, ts);  // R4 inverted
        verify(0, 50, ts);
    endtask

    task automatic t_irq_early();
        logic [31:0] ts;
        smp_irq = 7'h0;
        capture(500, 10, 2'd3, smp_addr, smp_am, 7'b100_0000, ts);  // R5, R9
        verify(500, 10, ts);
        smp_irq = 7'b000_0001;  // R10: triggers ignored once frozen
        repeat (20) tick();
        smp_irq = 7'h0;
        check(data_ready === 1'b1 && acquiring === 1'b0, "R10 ready holds",
              {30'd0, data_ready, acquiring}, 32'd2);
        verify(500, 10, ts);
    endtask

    initial begin
        t_reset();
        t_addr();
        t_am();
        t_am_not();
        t_irq_early();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule